// File: doc/BRIEF.md
# Write buffer with read-hazard check

This block sits between a write-through cache and the next memory level. Stores from the cache go into a small queue of address/data slots and are sent to memory in the order they arrived. The cache therefore does not wait on memory for a write, as long as a slot is free. Read misses also reach memory through this block, over the same single request port.

When a read miss is accepted, its address is compared with every slot that holds a write not yet sent. If no slot matches, the read is sent to memory before all queued writes, because the cache is waiting for it. If one or more slots match, the block first sends every write from the oldest up to and including the youngest matching one. Only then does it issue the read, so the read can never return stale data. At most one memory request is in flight at a time. A write ends at its request handshake. A read ends when its response returns, and that response is passed straight on to the cache.

Top module: `wbuf_raw_guard`

## Requirements
- R1: While reset is held, `mem_req_valid` and `rd_resp_valid` are 0, and `wr_ready` and `rd_ready` are 1.
- R2: Memory receives each accepted write exactly once, with its address and data unchanged, in the same order the writes were accepted (`mem_req_write`=1 marks a write request).
- R3: `wr_ready` stays 1 while fewer than DEPTH writes are pending. With DEPTH writes pending and no write draining in that cycle, `wr_ready` is 0.
- R4: In a cycle where the queue is full and its oldest write is accepted by memory, a new write is still accepted, and the queue is full again in the next cycle.
- R5: A read whose address matches no pending write is sent to memory (`mem_req_write`=0) before any write that was pending when the read was accepted.
- R6: A read whose address matches pending writes is issued only after every pending write up to and including the youngest match has been sent. Its response then carries the data of the most recent write to that address. Only writes accepted in earlier cycles than the read take part in the compare.
- R7: After a read handshake, `mem_req_valid` stays 0 until `mem_rsp_valid` returns that read's data.
- R8: The read response appears on `rd_resp_valid`/`rd_resp_data` in the same cycle as `mem_rsp_valid`/`mem_rsp_data`. `rd_ready` is 0 from the cycle after a read is accepted until that response.
- R9: When the block is idle, an accepted write, or an accepted read with no matching slot, is presented on the memory request port in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache offers a write |
| wr_ready | output | 1 | Write accepted this cycle when high with `wr_valid` |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Cache offers a read miss |
| rd_ready | output | 1 | Read slot free, read accepted when high with `rd_valid` |
| rd_addr | input | AW | Read-miss address |
| rd_resp_valid | output | 1 | Read data returned to the cache |
| rd_resp_data | output | DW | Returned read data |
| mem_req_valid | output | 1 | Request presented to memory |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data of the request |
| mem_rsp_valid | input | 1 | Memory returns read data |
| mem_rsp_data | input | DW | Memory read data |

## Verification
A write accepted at one edge is stored at that same edge. Its request becomes visible in the next cycle and leaves at the next edge where ready is high. A read follows the same one-cycle rule, with the hazard barrier added in front of it. The response is combinational, so it is due in the very cycle memory returns data. The bench drives its inputs just after a rising edge. It samples at the falling edge in between, which is the moment each handshake is already decided for the coming edge. The memory model answers a read a set number of cycles after the handshake. The order of requests is logged, so the bypass and the drain-before-read orderings are compared against strings of request kinds worked out by hand.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_WAIT   = 2'd1,
    RS_FLIGHT = 2'd2
  } rd_state_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_READ  = 2'd2
  } src_e;

  // slot index following p in a ring of 'depth' slots
  function automatic int unsigned wb_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // age of a slot counted from the oldest one (0 = oldest)
  function automatic int unsigned wb_age(int unsigned slot, int unsigned head,
                                         int unsigned depth);
    return (slot >= head) ? slot - head : slot + depth - head;
  endfunction

  // writes still to drain once a read is taken, given a drain in that cycle
  function automatic int unsigned wb_barrier(int unsigned need, logic drained);
    return (need != 0 && drained) ? need - 1 : need;
  endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [CW-1:0]            count,
  output logic                     full,
  output logic [DEPTH-1:0][AW-1:0] slot_addr,
  output logic [DEPTH-1:0]         slot_valid,
  output logic [PW-1:0]            head_ptr
);

  logic [PW-1:0]            head_q, tail_q;
  logic [CW-1:0]            cnt_q;
  logic [DEPTH-1:0][DW-1:0] slot_data;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          hit_tail, hit_head;

    assign hit_tail = push && (tail_q == PW'(g));
    assign hit_head = pop  && (head_q == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        data_q <= '0;
      end else if (hit_tail) begin
        vld_q  <= 1'b1;
        addr_q <= push_addr;
        data_q <= push_data;
      end else if (hit_head) begin
        vld_q  <= 1'b0;
      end
    end

    assign slot_valid[g] = vld_q;
    assign slot_addr[g]  = addr_q;
    assign slot_data[g]  = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= PW'(wb_next(32'(tail_q), DEPTH));
      if (pop)  head_q <= PW'(wb_next(32'(head_q), DEPTH));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_addr = slot_addr[head_q];
  assign head_data = slot_data[head_q];
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign head_ptr  = head_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH) || pop));

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> slot_valid[head_q]);

  p_count_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/wbuf_hazard.sv
module wbuf_hazard
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0]         slot_valid,
  input  logic [PW-1:0]            head_ptr,
  input  logic [AW-1:0]            probe_addr,
  output logic [CW-1:0]            need
);

  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = slot_valid[g] && (slot_addr[g] == probe_addr);
  end

  // need = age of the youngest matching slot + 1, or 0 without a match
  always_comb begin
    logic [CW-1:0] cand;
    need = '0;
    cand = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        cand = CW'(wb_age(32'(i), 32'(head_ptr), DEPTH) + 1);
        if (cand > need) need = cand;
      end
    end
  end

endmodule

// File: rtl/wbuf_sched.sv
module wbuf_sched
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  input  logic [CW-1:0] need,
  input  logic [CW-1:0] fifo_count,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_req_ready,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          rd_resp_valid,
  output logic          pop
);

  rd_state_e     state_q;
  logic [AW-1:0] rd_addr_q;
  logic [CW-1:0] barrier_q;
  src_e          src;
  logic          rd_take, rd_fire;

  always_comb begin
    if (state_q == RS_WAIT && barrier_q == '0)
      src = SRC_READ;
    else if (state_q != RS_FLIGHT && fifo_count != '0)
      src = SRC_WRITE;
    else
      src = SRC_NONE;
  end

  assign mem_req_valid = (src != SRC_NONE);
  assign mem_req_write = (src == SRC_WRITE);
  assign mem_req_addr  = (src == SRC_READ) ? rd_addr_q : head_addr;
  assign mem_req_wdata = head_data;

  assign pop           = (src == SRC_WRITE) && mem_req_ready;
  assign rd_fire       = (src == SRC_READ) && mem_req_ready;
  assign rd_ready      = (state_q == RS_IDLE);
  assign rd_take       = rd_valid && rd_ready;
  assign rd_resp_valid = (state_q == RS_FLIGHT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RS_IDLE;
      rd_addr_q <= '0;
      barrier_q <= '0;
    end else begin
      case (state_q)
        RS_IDLE: if (rd_take) begin
          state_q   <= RS_WAIT;
          rd_addr_q <= rd_addr;
          barrier_q <= CW'(wb_barrier(32'(need), pop));
        end
        RS_WAIT: begin
          if (rd_fire) state_q <= RS_FLIGHT;
          else if (pop && barrier_q != '0) barrier_q <= barrier_q - CW'(1);
        end
        RS_FLIGHT: if (mem_rsp_valid) state_q <= RS_IDLE;
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_FLIGHT) |-> !mem_req_valid);

  p_read_after_barrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (barrier_q == '0));

  p_barrier_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_WAIT && barrier_q != '0 && !pop) |=> $stable(barrier_q));

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_WAIT && barrier_q == '0 && fifo_count != '0)
      |-> (mem_req_valid && !mem_req_write));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_take) |-> !rd_ready);

endmodule

// File: rtl/wbuf_raw_guard.sv
module wbuf_raw_guard #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic                     push, pop, full;
  logic [CW-1:0]            count, need;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0]         slot_valid;
  logic [PW-1:0]            head_ptr;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;

  // a full queue still takes a write when its oldest entry leaves this cycle
  assign wr_ready     = !full || pop;
  assign push         = wr_valid && wr_ready;
  assign rd_resp_data = mem_rsp_data;

  wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (wr_addr),
    .push_data  (wr_data),
    .pop        (pop),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .count      (count),
    .full       (full),
    .slot_addr  (slot_addr),
    .slot_valid (slot_valid),
    .head_ptr   (head_ptr)
  );

  wbuf_hazard #(.DEPTH(DEPTH), .AW(AW)) u_hazard (
    .slot_addr  (slot_addr),
    .slot_valid (slot_valid),
    .head_ptr   (head_ptr),
    .probe_addr (rd_addr),
    .need       (need)
  );

  wbuf_sched #(.AW(AW), .DW(DW), .CW(CW)) u_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_addr       (rd_addr),
    .rd_ready      (rd_ready),
    .need          (need),
    .fifo_count    (count),
    .head_addr     (head_addr),
    .head_data     (head_data),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .rd_resp_valid (rd_resp_valid),
    .pop           (pop)
  );

  p_full_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |=> full);

  p_pending_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(push) && !rd_resp_valid && rd_ready) |-> mem_req_valid);

endmodule

// File: tb/wbuf_raw_guard_bench.sv
module wbuf_raw_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk, rst_n;
  logic          wr_valid, wr_ready, rd_valid, rd_ready;
  logic [AW-1:0] wr_addr, rd_addr, mem_req_addr;
  logic [DW-1:0] wr_data, rd_resp_data, mem_req_wdata, mem_rsp_data;
  logic          rd_resp_valid, mem_req_valid, mem_req_ready, mem_req_write;
  logic          mem_rsp_valid;
  logic          mem_stall;
  int            rsp_delay;

  int n_chk = 0;
  int n_fail = 0;
  int n_acc_wr = 0;
  int n_mem_wr = 0;
  bit done = 0;

  logic [63:0] exp_wr_q[$];
  logic [31:0] exp_rd_q[$];
  bit          fire_wr_log[$];
  int          fire_pend_log[$];
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];

  assign mem_req_ready = !mem_stall;

  wbuf_raw_guard #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wbuf_raw_guard (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] init_val(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // memory model and scoreboard monitor, sampled mid-cycle
  initial begin
    bit          rsp_wait;
    int          rsp_cnt;
    logic [31:0] rsp_next;
    logic [63:0] e;
    rsp_wait = 0; rsp_cnt = 0; rsp_next = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_wait)
          chk(!mem_req_valid, "R7", "request while read in flight", 64'(mem_req_valid), 64'd0);
        if (mem_rsp_valid) begin
          chk(rd_resp_valid && rd_resp_data == mem_rsp_data, "R8", "response forwarded",
              {31'd0, rd_resp_valid, rd_resp_data}, {31'd0, 1'b1, mem_rsp_data});
          if (exp_rd_q.size() == 0)
            chk(1'b0, "R6", "unexpected read data", 64'(rd_resp_data), 64'd0);
          else begin
            logic [31:0] x;
            x = exp_rd_q.pop_front();
            chk(rd_resp_data == x, "R6", "read data", 64'(rd_resp_data), 64'(x));
          end
        end else if (rd_resp_valid)
          chk(1'b0, "R8", "response without memory data", 64'd1, 64'd0);
        if (mem_req_valid && mem_req_ready) begin
          if (mem_req_write) begin
            if (exp_wr_q.size() == 0)
              chk(1'b0, "R2", "unexpected write", {mem_req_addr, mem_req_wdata}, 64'd0);
            else begin
              e = exp_wr_q.pop_front();
              chk({mem_req_addr, mem_req_wdata} == e, "R2", "write order/content",
                  {mem_req_addr, mem_req_wdata}, e);
            end
            mem_m[mem_req_addr] = mem_req_wdata;
            n_mem_wr++;
            fire_wr_log.push_back(1'b1);
            fire_pend_log.push_back(n_acc_wr - n_mem_wr + 1);
          end else begin
            fire_wr_log.push_back(1'b0);
            fire_pend_log.push_back(n_acc_wr - n_mem_wr);
            rsp_next = mem_m.exists(mem_req_addr) ? mem_m[mem_req_addr] : init_val(mem_req_addr);
            rsp_wait = 1;
            rsp_cnt  = rsp_delay;
          end
        end
      end
      @(posedge clk); #1;
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        rsp_wait = 0;
      end else if (rsp_wait) begin
        if (rsp_cnt <= 1) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_next;
        end else rsp_cnt--;
      end
    end
  end

  // driver tasks: called just after a rising edge
  task automatic do_write(input logic [31:0] a, input logic [31:0] d, output int waited);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; waited = 0;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
      waited++;
    end
    exp_wr_q.push_back({a, d});
    ref_m[a] = d;
    n_acc_wr++;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a);
    rd_valid = 1'b1; rd_addr = a;
    forever begin
      @(negedge clk);
      if (rd_ready) break;
    end
    exp_rd_q.push_back(ref_m.exists(a) ? ref_m[a] : init_val(a));
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk); #1;
      if (n_acc_wr == n_mem_wr && exp_rd_q.size() == 0 && rd_ready && !mem_rsp_valid) break;
    end
    @(posedge clk); #1;
  endtask

  function automatic string kinds_from(int start);
    string s = "";
    for (int i = start; i < fire_wr_log.size(); i++) s = {s, fire_wr_log[i] ? "W" : "R"};
    return s;
  endfunction

  task automatic chk_order(input int start, input string exp, input string req);
    string got;
    got = kinds_from(start);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s request order: actual %s expected %s", req, got, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int          w, start;
    logic [15:0] lfsr;
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    mem_stall = 1'b0; rsp_delay = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!mem_req_valid, "R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk(!rd_resp_valid, "R1", "rd_resp_valid in reset", 64'(rd_resp_valid), 64'd0);
    chk(wr_ready, "R1", "wr_ready in reset", 64'(wr_ready), 64'd1);
    chk(rd_ready, "R1", "rd_ready in reset", 64'(rd_ready), 64'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 write latency from idle
    do_write(32'h10, 32'h1111_0001, w);
    @(negedge clk);
    chk(mem_req_valid && mem_req_write && mem_req_addr == 32'h10, "R9", "write presented next cycle",
        {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, 32'h10});
    @(posedge clk); #1;
    wait_idle();

    // R9 read latency from idle, data from drained write (R6)
    do_read(32'h10);
    @(negedge clk);
    chk(mem_req_valid && !mem_req_write && mem_req_addr == 32'h10, "R9", "read presented next cycle",
        {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, 32'h10});
    @(posedge clk); #1;
    wait_idle();

    // R2 / R3 burst while memory keeps up: never stalls
    for (int i = 0; i < 10; i++) begin
      do_write(32'h40 + 32'(4 * i), 32'hB000_0000 + 32'(i), w);
      chk(w == 0, "R3", "burst write stalled", 64'(w), 64'd0);
    end
    wait_idle();

    // R3 fill to DEPTH with memory stalled
    mem_stall = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      do_write(32'h80 + 32'(4 * i), 32'hC000_0000 + 32'(i), w);
      chk(w == 0, "R3", "write with free slot stalled", 64'(w), 64'd0);
    end
    @(negedge clk);
    chk(!wr_ready, "R3", "wr_ready when full", 64'(wr_ready), 64'd0);
    @(posedge clk); #1;
    // R4 drain and accept in the same cycle
    mem_stall = 1'b0;
    do_write(32'h90, 32'hC0DE_0090, w);
    chk(w == 0, "R4", "write during drain of full queue", 64'(w), 64'd0);
    mem_stall = 1'b1;
    @(negedge clk);
    chk(!wr_ready, "R4", "queue full again after swap", 64'(wr_ready), 64'd0);
    @(posedge clk); #1;
    mem_stall = 1'b0;
    wait_idle();

    // R5 read bypasses queued writes
    mem_stall = 1'b1;
    for (int i = 0; i < 3; i++) do_write(32'hA0 + 32'(4 * i), 32'hD000_0000 + 32'(i), w);
    do_read(32'h200);
    @(negedge clk);
    chk(!rd_ready, "R8", "rd_ready while read busy", 64'(rd_ready), 64'd0);
    @(posedge clk); #1;
    start = fire_wr_log.size();
    mem_stall = 1'b0;
    wait_idle();
    chk(!fire_wr_log[start] && fire_pend_log[start] == 3, "R5", "read ahead of 3 writes",
        {32'(fire_wr_log[start]), 32'(fire_pend_log[start])}, {32'd0, 32'd3});
    chk_order(start, "RWWW", "R5");

    // R6 match in the middle: drain through youngest match
    mem_stall = 1'b1;
    do_write(32'h300, 32'hE000_0001, w);
    do_write(32'h304, 32'hE000_0002, w);
    do_write(32'h300, 32'hE000_0003, w);
    do_write(32'h308, 32'hE000_0004, w);
    do_read(32'h300);
    start = fire_wr_log.size();
    mem_stall = 1'b0;
    wait_idle();
    chk_order(start, "WWWRW", "R6");

    // R6 match at the youngest slot
    mem_stall = 1'b1;
    for (int i = 0; i < DEPTH; i++) do_write(32'h400 + 32'(4 * i), 32'hE100_0000 + 32'(i), w);
    do_read(32'h40C);
    start = fire_wr_log.size();
    mem_stall = 1'b0;
    wait_idle();
    chk_order(start, "WWWWR", "R6");

    // R6 match at the oldest slot only
    mem_stall = 1'b1;
    do_write(32'h500, 32'hE200_0000, w);
    do_write(32'h504, 32'hE200_0001, w);
    do_read(32'h500);
    start = fire_wr_log.size();
    mem_stall = 1'b0;
    wait_idle();
    chk_order(start, "WRW", "R6");

    // R7 long read latency with writes queued behind
    rsp_delay = 4;
    mem_stall = 1'b1;
    do_write(32'h600, 32'hF000_0000, w);
    do_read(32'h700);
    do_write(32'h604, 32'hF000_0001, w);
    start = fire_wr_log.size();
    mem_stall = 1'b0;
    wait_idle();
    chk_order(start, "RWW", "R7");
    rsp_delay = 1;

    // mixed traffic on a small address set
    lfsr = 16'hACE1;
    for (int it = 0; it < 150; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_stall = lfsr[0] && ((n_acc_wr - n_mem_wr) < DEPTH - 1) && rd_ready;
      rsp_delay = lfsr[1] ? 2 : 1;
      if (lfsr[7:5] < 3'd5)
        do_write(32'h800 + {27'd0, lfsr[4:2], 2'b00}, {lfsr, 16'(it)}, w);
      else
        do_read(32'h800 + {27'd0, lfsr[4:2], 2'b00});
    end
    mem_stall = 1'b0;
    wait_idle();
    chk(exp_wr_q.size() == 0, "R2", "writes left undrained", 64'(exp_wr_q.size()), 64'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule